// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block merges the interrupt sources of a 16550-class serial controller into one interrupt request line and an 8-bit identification byte that software reads to learn which source needs service. It holds the four-bit interrupt enable register and the hidden "transmit holding empty" pending flag. It also takes the line-status error flags, the receive data-ready flag, the receive FIFO fill count and trigger level, the FIFO-enable flag, a character-timeout flag and the modem-status delta flags.

The sources are ranked by a fixed five-level priority. The identification byte always reports only the highest pending enabled source. The level inputs feed a combinational path to the outputs. Register-access strobes from the bus decode (enable write, identification read) and the transmit-empty event strobe update internal state at the clock edge. Their effect shows on the outputs right after that edge.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the enable register and the transmit-empty pending flag are clear, the identification byte reads 0x01 and the interrupt line is low.
- R2: When several sources are active at once, the reported one follows this order, highest first: line status, character timeout, receive data, transmit empty, modem status.
- R3: The identification low nibble is 0x6 for line status, 0xC for character timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status and 0x1 when nothing is pending.
- R4: The line-status source is active when enable bit 2 is set and any of the four error inputs (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) is set.
- R5: The character-timeout source is reported only when enable bit 0 (receive data) is set.
- R6: The receive-data source needs enable bit 0 and data-ready. With FIFOs disabled, data-ready alone is enough. With FIFOs enabled, the fill count must also be at least the trigger level.
- R7: The transmit-empty pending flag is set by the empty event strobe, and by an enable-register write while the holding register is empty. Any identification read clears it, but a set in the same cycle wins over the clear. The flag is reported only when enable bit 1 is set.
- R8: The modem-status source is active when enable bit 3 is set and any of the four delta inputs is set.
- R9: Identification bits 7:6 read 11 while FIFOs are enabled and 00 otherwise. Bits 5:4 read 0.
- R10: The interrupt line is high exactly when the identification low nibble differs from 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 4 | Enable bits: 0 rx data, 1 tx empty, 2 line status, 3 modem |
| iid_rd | input | 1 | Identification-register read strobe |
| thr_empty | input | 1 | Holding register currently empty (level) |
| thr_empty_evt | input | 1 | Holding path just became empty (strobe) |
| lsr_err | input | 4 | Overrun, parity, framing, break flags |
| data_ready | input | 1 | Receive data-ready flag |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CW | Receive FIFO fill count |
| trig_level | input | CW | Receive trigger level |
| timeout_pend | input | 1 | Character-timeout pending flag |
| msr_delta | input | 4 | Modem-status delta flags |
| ier | output | 4 | Current enable register |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The level inputs reach the identification byte and the interrupt line in the same cycle with no register between them. Enable writes, identification reads and empty events change the outputs only after the clock edge on which the strobe is sampled. The bench therefore drives inputs and strobes on the falling edge, lets exactly one rising edge pass, and samples one nanosecond later. That single sampling point is correct for both kinds of result.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ier_wr,
  input  logic [3:0]    ier_wdata,
  input  logic          iid_rd,
  input  logic          thr_empty,
  input  logic          thr_empty_evt,
  input  logic [3:0]    lsr_err,
  input  logic          data_ready,
  input  logic          fifo_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] trig_level,
  input  logic          timeout_pend,
  input  logic [3:0]    msr_delta,
  output logic [3:0]    ier,
  output logic [7:0]    iid,
  output logic          irq
);

  localparam logic [3:0] CODE_LS   = 4'h6;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_RX   = 4'h4;
  localparam logic [3:0] CODE_TX   = 4'h2;
  localparam logic [3:0] CODE_MS   = 4'h0;
  localparam logic [3:0] CODE_NONE = 4'h1;

  logic       en_q;
  logic [3:0] ier_q;
  logic       tx_pend;
  logic       tx_set;
  logic       src_ls, src_tmo, src_rx, src_tx, src_ms;
  logic       rx_level_ok;
  logic [3:0] code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata;

  assign tx_set = thr_empty_evt | (ier_wr & thr_empty);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_pend <= 1'b0;
    else if (tx_set) tx_pend <= 1'b1;
    else if (iid_rd) tx_pend <= 1'b0;

  assign rx_level_ok = !fifo_en || (rx_count >= trig_level);

  assign src_ls  = ier_q[2] & (|lsr_err);
  assign src_tmo = ier_q[0] & timeout_pend;
  assign src_rx  = ier_q[0] & data_ready & rx_level_ok;
  assign src_tx  = ier_q[1] & tx_pend;
  assign src_ms  = ier_q[3] & (|msr_delta);

  always_comb begin
    if (src_ls)       code = CODE_LS;
    else if (src_tmo) code = CODE_TMO;
    else if (src_rx)  code = CODE_RX;
    else if (src_tx)  code = CODE_TX;
    else if (src_ms)  code = CODE_MS;
    else              code = CODE_NONE;
  end

  assign ier = ier_q;
  assign iid = {{2{fifo_en}}, 2'b00, code};
  assign irq = (code != CODE_NONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else en_q <= 1'b1;

  assert_ls_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && |lsr_err) |-> (iid[3:0] == 4'h6));

  assert_tmo_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ier[0] |-> (iid[3:0] != 4'hC));

  assert_rx_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iid[3:0] == 4'h4) |-> (data_ready && (!fifo_en || rx_count >= trig_level)));

  assert_tx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n || !en_q)
    ($past(iid_rd) && !$past(thr_empty_evt) && !$past(ier_wr)) |-> (iid[3:0] != 4'h2));

  assert_tx_set_R7: assert property (@(posedge clk) disable iff (!rst_n || !en_q)
    ($past(thr_empty_evt) && ier[1] && !ier[2] && !ier[0]) |-> (iid[3:0] == 4'h2));

  assert_ms_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iid[3:0] == 4'h0) |-> (ier[3] && |msr_delta));

  assert_fifo_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iid[7:6] == {2{fifo_en}}) && (iid[5:4] == 2'b00));

  assert_irq_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (iid[3:0] != 4'h1));

endmodule

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0;
  logic ier_wr = 0, iid_rd = 0, thr_empty = 0, thr_empty_evt = 0;
  logic [3:0] ier_wdata = 0, lsr_err = 0, msr_delta = 0;
  logic data_ready = 0, fifo_en = 0, timeout_pend = 0;
  logic [CW-1:0] rx_count = 0, trig_level = 1;
  logic [3:0] ier;
  logic [7:0] iid;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  uart_irq_prio i_uart_irq_prio (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iid_rd(iid_rd), .thr_empty(thr_empty), .thr_empty_evt(thr_empty_evt),
    .lsr_err(lsr_err), .data_ready(data_ready), .fifo_en(fifo_en),
    .rx_count(rx_count), .trig_level(trig_level), .timeout_pend(timeout_pend),
    .msr_delta(msr_delta), .ier(ier), .iid(iid), .irq(irq));

  // {ier, lsr_err, dr, fifo_en, count, trig, tmo, msr_delta, expected iid}
  function automatic logic [32:0] v(logic [3:0] e, logic [3:0] l, logic d, logic f,
    logic [4:0] c, logic [4:0] t, logic o, logic [3:0] m, logic [7:0] x);
    return {e, l, d, f, c, t, o, m, x};
  endfunction

  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    v(4'h0, 4'hF, 1, 0,  0,  1, 1, 4'hF, 8'h01),
    v(4'h4, 4'h2, 1, 0,  0,  1, 1, 4'hF, 8'h06),
    v(4'h4, 4'h0, 1, 0,  0,  1, 0, 4'h0, 8'h01),
    v(4'h1, 4'h0, 1, 0,  0,  1, 1, 4'h0, 8'h0C),
    v(4'h5, 4'h8, 1, 0,  0,  1, 1, 4'h0, 8'h06),
    v(4'h4, 4'h0, 0, 0,  0,  1, 1, 4'h0, 8'h01),
    v(4'h1, 4'h0, 1, 0,  0,  1, 0, 4'h0, 8'h04),
    v(4'h1, 4'h0, 1, 1,  3,  4, 0, 4'h0, 8'hC1),
    v(4'h1, 4'h0, 1, 1,  4,  4, 0, 4'h0, 8'hC4),
    v(4'h1, 4'h0, 1, 1, 14, 14, 0, 4'h0, 8'hC4),
    v(4'h1, 4'h0, 0, 1,  4,  4, 0, 4'h0, 8'hC1),
    v(4'h8, 4'h0, 0, 0,  0,  1, 0, 4'h4, 8'h00),
    v(4'h9, 4'h0, 1, 0,  0,  1, 0, 4'h1, 8'h04),
    v(4'h8, 4'h0, 0, 1,  0,  1, 0, 4'h0, 8'hC1)
  };

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (iid !== exp || irq !== (exp[3:0] != 4'h1)) begin
      errors++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b", req, iid, irq, exp, exp[3:0] != 4'h1);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic write_ier(logic [3:0] val);
    @(negedge clk); ier_wr = 1; ier_wdata = val;
    tick(); ier_wr = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 8'h01);
    checks++;
    if (ier !== 4'h0) begin errors++; $display("FAIL R1: ier=%h expected 0", ier); end
    @(negedge clk) rst_n = 1;
    tick();

    // R2 R3 R4 R5 R6 R8 R9 R10 via table
    for (int i = 0; i < NV; i++) begin
      write_ier(VEC[i][32:29]);
      @(negedge clk);
      lsr_err = VEC[i][28:25]; data_ready = VEC[i][24]; fifo_en = VEC[i][23];
      rx_count = VEC[i][22:18]; trig_level = VEC[i][17:13];
      timeout_pend = VEC[i][12]; msr_delta = VEC[i][11:8];
      tick();
      check($sformatf("R2/R3 vector %0d", i), VEC[i][7:0]);
    end

    @(negedge clk);
    lsr_err = 0; data_ready = 0; fifo_en = 0; timeout_pend = 0; msr_delta = 0;
    rx_count = 0; trig_level = 1;

    // R7: enable write while holding register empty sets pending
    thr_empty = 1;
    write_ier(4'h2);
    check("R7 ier write sets tx pending", 8'h02);
    // R7: identification read clears
    @(negedge clk) iid_rd = 1; tick(); iid_rd = 0;
    check("R7 read clears tx pending", 8'h01);
    // R7: empty event sets
    @(negedge clk) thr_empty_evt = 1; tick(); thr_empty_evt = 0;
    check("R7 empty event sets", 8'h02);
    // R7: set and clear same cycle, set wins
    @(negedge clk) begin thr_empty_evt = 1; iid_rd = 1; end
    tick(); thr_empty_evt = 0; iid_rd = 0;
    check("R7 set wins over clear", 8'h02);
    // R7 masked, then unmasked with holding register not empty keeps pending
    thr_empty = 0;
    write_ier(4'h0);
    check("R7 masked", 8'h01);
    write_ier(4'h2);
    check("R7 pending kept while masked", 8'h02);
    // R2: transmit beats modem, modem after read
    @(negedge clk) msr_delta = 4'h8;
    write_ier(4'hA);
    check("R2 tx over modem", 8'h02);
    @(negedge clk) iid_rd = 1; tick(); iid_rd = 0;
    check("R8 modem after tx cleared", 8'h00);
    // R9 with FIFO bits and modem
    @(negedge clk) fifo_en = 1; tick();
    check("R9 fifo bits with modem", 8'hC0);
    // R4 each error bit alone
    write_ier(4'h4);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk) lsr_err = 4'(1 << b); tick();
      check($sformatf("R4 error bit %0d", b), 8'hC6);
    end
    @(negedge clk) lsr_err = 0; tick();
    check("R10 no source", 8'hC1);
    // R1: reset mid-run clears enables and pending
    @(negedge clk) thr_empty_evt = 1; tick(); thr_empty_evt = 0;
    @(negedge clk) rst_n = 0; #1;
    check("R1 reset mid-run", 8'hC1);
    @(negedge clk) rst_n = 1; fifo_en = 0; msr_delta = 0;
    write_ier(4'h2);
    check("R1 pending cleared by reset", 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule